// File: doc/BRIEF.md
# Holdover Frequency-Steering Loop Core

This block is the digital heart of a very slow frequency-locking loop. Once per sample period, about 20 times a second, it receives a signed phase-error sample. Each sample is one count of 5 ns. The block subtracts a captured zero-error base from the sample and passes the result through a first-order low-pass filter. The filter output is then integrated into a control word. The control word leaves the block in two forms: as a parallel value, and as a pulse-width-modulated bitstream. The bitstream feeds an external analog smoothing filter that steers the oscillator.

The loop opens by itself in two cases: when the reference indicator drops, or when two consecutive accepted samples differ by more than 134 counts (a 670 ns jump). While the loop is open, the control word is frozen at its last good value, so the oscillator keeps running in holdover. The loop restarts on the next sample that arrives with the reference present. That sample becomes the new zero-error base and the filter is cleared, so the frozen control word does not step.

All arithmetic uses shifts, not multipliers. The filter keeps `FRAC_W` fraction bits, and the accumulator keeps the same fraction bits below the 15-bit control value.

Top module: `holdover_loop_core`

## Requirements
- R1: After reset, `ctrl_word` is 16384 (mid-scale), `holding` is 1 and `loop_fail` is 0.
- R2: While not locked, a sample with `ref_present` high captures `phase_err` as the zero-error base. The same sample clears `holding` one clock later and leaves `ctrl_word` unchanged.
- R3: In lock, a sample updates the filter and the accumulator with signed arithmetic shifts. The error is e = phase_err - base. The filter update is f += ((e<<12) - f) >>> 3, and the accumulator update is a += f >>> 4, using the new f. `ctrl_word` = a >> 12, visible two clocks after the sample.
- R4: In lock, a sample whose difference from the previous accepted sample is greater than 134 or less than -134 is not applied and sets `holding`. A difference of exactly ±134 is applied normally.
- R5: While locked, `ref_present` low sets `holding` on the next clock, with or without a sample. Samples that arrive without the reference leave `ctrl_word` unchanged.
- R6: In holdover, a sample with `ref_present` high re-captures the base from that sample, clears the filter, clears `holding`, and leaves `ctrl_word` unchanged.
- R7: The accumulator saturates, so `ctrl_word` stays at 0 or 32767 instead of wrapping.
- R8: `loop_fail` is 1 exactly while `ctrl_word` is below 1024 or above 31743.
- R9: `pwm_out` has a period of 32768 clocks and is high for exactly the duty value of each period. The duty value is reloaded from `ctrl_word` only at the period boundary.
- R10: A sample that arrives in the same clock as a reference loss is not applied, and the loop opens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_valid | input | 1 | One-clock strobe marking a new phase-error sample |
| phase_err | input | 16 | Signed phase-error sample, 5 ns per count |
| ref_present | input | 1 | High while the reference is usable |
| ctrl_word | output | 15 | Frozen or tracking control value |
| pwm_out | output | 1 | Pulse-width-modulated control bitstream |
| holding | output | 1 | High while the loop is open (holdover) |
| loop_fail | output | 1 | Control value outside the allowed band |

## Verification
The cases that matter most are those where a sample strobe lands in the same clock as an event that opens or closes the loop. In one, the strobe arrives together with the reference dropping. In another, it carries a jump just beyond the threshold. In a third, it carries the reference's return while the loop is held. The stimulus table places such samples on purpose, next to a sample whose step sits exactly at the threshold. After each of them the bench checks that the control word is exactly what a model built from the requirements predicts, with no update applied, and that `holding` has the expected level.

// File: rtl/holdover_pkg.sv
package holdover_pkg;
  typedef enum logic [1:0] {
    ST_ACQ  = 2'd0,
    ST_LOCK = 2'd1,
    ST_HOLD = 2'd2
  } loop_state_e;
endpackage

// File: rtl/holdover_supervisor.sv
module holdover_supervisor
  import holdover_pkg::*;
#(
  parameter int ERR_W    = 16,
  parameter int JUMP_LIM = 134
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    sample_valid,
  input  logic                    ref_present,
  input  logic signed [ERR_W-1:0] phase_err,
  output logic                    do_capture,
  output logic                    do_update,
  output logic                    holding
);
  localparam int signed LIM = JUMP_LIM;

  loop_state_e             st_q, st_nx;
  logic signed [ERR_W-1:0] prev_q;
  logic signed [ERR_W:0]   step;
  logic                    jump;
  logic                    locked;

  always_comb begin
    step   = {phase_err[ERR_W-1], phase_err} - {prev_q[ERR_W-1], prev_q};
    jump   = (int'(step) > LIM) || (int'(step) < -LIM);
    locked = (st_q == ST_LOCK);
    do_capture = sample_valid && ref_present && !locked;
    do_update  = sample_valid && ref_present && locked && !jump;
    st_nx = st_q;
    if (locked) begin
      if (!ref_present || (sample_valid && jump)) st_nx = ST_HOLD;
    end else if (do_capture) begin
      st_nx = ST_LOCK;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_ACQ;
      prev_q  <= '0;
      holding <= 1'b1;
    end else begin
      st_q    <= st_nx;
      holding <= (st_nx != ST_LOCK);
      if (do_capture || do_update) prev_q <= phase_err;
    end
  end
endmodule

// File: rtl/holdover_loop_filter.sv
module holdover_loop_filter #(
  parameter int ERR_W    = 16,
  parameter int CTRL_W   = 15,
  parameter int FRAC_W   = 12,
  parameter int F_SHIFT  = 3,
  parameter int KI_SHIFT = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       do_capture,
  input  logic                       do_update,
  input  logic signed [ERR_W-1:0]    phase_err,
  output logic [CTRL_W+FRAC_W-1:0]   acc_q
);
  localparam int AW = CTRL_W + FRAC_W;
  localparam int FW = ERR_W + 1 + FRAC_W;
  localparam int SW = ((FW > AW) ? FW : AW) + 3;
  localparam logic signed [SW-1:0] ACC_MAX = {{(SW-AW){1'b0}}, {AW{1'b1}}};
  localparam logic [AW-1:0] ACC_MID = {1'b1, {(AW-1){1'b0}}};

  logic signed [ERR_W-1:0] base_q;
  logic signed [FW-1:0]    filt_q;
  logic signed [ERR_W:0]   err_rel;
  logic signed [SW-1:0]    err_fix, filt_ext, diff, filt_nx, acc_ext, acc_sum;
  logic [AW-1:0]           acc_nx;

  always_comb begin
    err_rel  = {phase_err[ERR_W-1], phase_err} - {base_q[ERR_W-1], base_q};
    err_fix  = SW'(err_rel) <<< FRAC_W;
    filt_ext = SW'(filt_q);
    diff     = err_fix - filt_ext;
    filt_nx  = filt_ext + (diff >>> F_SHIFT);
    acc_ext  = SW'(acc_q);
    acc_sum  = acc_ext + (filt_nx >>> KI_SHIFT);
    if (acc_sum < 0)            acc_nx = '0;
    else if (acc_sum > ACC_MAX) acc_nx = '1;
    else                        acc_nx = acc_sum[AW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      filt_q <= '0;
      acc_q  <= ACC_MID;
    end else if (do_capture) begin
      base_q <= phase_err;
      filt_q <= '0;
    end else if (do_update) begin
      filt_q <= filt_nx[FW-1:0];
      acc_q  <= acc_nx;
    end
  end
endmodule

// File: rtl/holdover_ctrl_out.sv
module holdover_ctrl_out #(
  parameter int CTRL_W  = 15,
  parameter int FRAC_W  = 12,
  parameter int FAIL_LO = 1024,
  parameter int FAIL_HI = 31743
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [CTRL_W+FRAC_W-1:0] acc_q,
  output logic [CTRL_W-1:0]        ctrl_word,
  output logic                     loop_fail
);
  localparam int AW = CTRL_W + FRAC_W;
  localparam logic [CTRL_W-1:0] MID = {1'b1, {(CTRL_W-1){1'b0}}};

  logic [CTRL_W-1:0] ctrl_nx;

  always_comb ctrl_nx = acc_q[AW-1 -: CTRL_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_word <= MID;
      loop_fail <= 1'b0;
    end else begin
      ctrl_word <= ctrl_nx;
      loop_fail <= (int'(ctrl_nx) < FAIL_LO) || (int'(ctrl_nx) > FAIL_HI);
    end
  end
endmodule

// File: rtl/holdover_pwm.sv
module holdover_pwm #(
  parameter int CTRL_W = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CTRL_W-1:0] ctrl_word,
  output logic              pwm_out
);
  localparam logic [CTRL_W-1:0] MID = {1'b1, {(CTRL_W-1){1'b0}}};

  logic [CTRL_W-1:0] cnt_q, duty_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      duty_q  <= MID;
      pwm_out <= 1'b0;
    end else begin
      cnt_q   <= cnt_q + 1'b1;
      pwm_out <= (cnt_q < duty_q);
      if (cnt_q == '1) duty_q <= ctrl_word;
    end
  end
endmodule

// File: rtl/holdover_loop_core.sv
module holdover_loop_core #(
  parameter int ERR_W    = 16,
  parameter int CTRL_W   = 15,
  parameter int FRAC_W   = 12,
  parameter int F_SHIFT  = 3,
  parameter int KI_SHIFT = 4,
  parameter int JUMP_LIM = 134,
  parameter int FAIL_LO  = 1024,
  parameter int FAIL_HI  = 31743
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    sample_valid,
  input  logic signed [ERR_W-1:0] phase_err,
  input  logic                    ref_present,
  output logic [CTRL_W-1:0]       ctrl_word,
  output logic                    pwm_out,
  output logic                    holding,
  output logic                    loop_fail
);
  localparam int AW = CTRL_W + FRAC_W;

  logic          do_capture, do_update;
  logic [AW-1:0] acc_q;

  holdover_supervisor #(.ERR_W(ERR_W), .JUMP_LIM(JUMP_LIM)) u_sup (
    .clk(clk), .rst(rst), .sample_valid(sample_valid), .ref_present(ref_present),
    .phase_err(phase_err), .do_capture(do_capture), .do_update(do_update),
    .holding(holding)
  );

  holdover_loop_filter #(
    .ERR_W(ERR_W), .CTRL_W(CTRL_W), .FRAC_W(FRAC_W),
    .F_SHIFT(F_SHIFT), .KI_SHIFT(KI_SHIFT)
  ) u_filt (
    .clk(clk), .rst(rst), .do_capture(do_capture), .do_update(do_update),
    .phase_err(phase_err), .acc_q(acc_q)
  );

  holdover_ctrl_out #(
    .CTRL_W(CTRL_W), .FRAC_W(FRAC_W), .FAIL_LO(FAIL_LO), .FAIL_HI(FAIL_HI)
  ) u_out (
    .clk(clk), .rst(rst), .acc_q(acc_q), .ctrl_word(ctrl_word), .loop_fail(loop_fail)
  );

  holdover_pwm #(.CTRL_W(CTRL_W)) u_pwm (
    .clk(clk), .rst(rst), .ctrl_word(ctrl_word), .pwm_out(pwm_out)
  );
endmodule

// File: rtl/holdover_loop_chk.sv
module holdover_loop_chk #(
  parameter int CTRL_W  = 15,
  parameter int FAIL_LO = 1024,
  parameter int FAIL_HI = 31743
) (
  input logic              clk,
  input logic              rst,
  input logic              ref_present,
  input logic              holding,
  input logic [CTRL_W-1:0] ctrl_word,
  input logic              loop_fail
);
  // R5: losing the reference opens the loop on the next clock
  p_refloss_opens_r5: assert property (@(posedge clk) disable iff (rst)
    (!ref_present && !holding) |=> holding);

  // R5: the control word is frozen during holdover
  p_hold_freeze_r5: assert property (@(posedge clk) disable iff (rst)
    (holding && $past(holding)) |-> $stable(ctrl_word));

  // R6: the restart does not step the control word
  p_restart_no_step_r6: assert property (@(posedge clk) disable iff (rst)
    (!holding && $past(holding)) |=> $stable(ctrl_word));

  // R8: the failure flag tracks the allowed band
  p_fail_band_r8: assert property (@(posedge clk) disable iff (rst)
    loop_fail == ((int'(ctrl_word) < FAIL_LO) || (int'(ctrl_word) > FAIL_HI)));
endmodule

bind holdover_loop_core holdover_loop_chk #(
  .CTRL_W(CTRL_W), .FAIL_LO(FAIL_LO), .FAIL_HI(FAIL_HI)
) u_chk (
  .clk(clk), .rst(rst), .ref_present(ref_present), .holding(holding),
  .ctrl_word(ctrl_word), .loop_fail(loop_fail)
);

// File: tb/tb_holdover_loop_core.sv
module tb_holdover_loop_core;
  localparam int CLK_PERIOD = 10;
  localparam int PERIOD     = 32768;
  localparam int NVEC       = 14;
  // {ref_present, phase_err}
  localparam logic [16:0] VEC [NVEC] = '{
    {1'b1, 16'd0},    {1'b1, 16'd100},  {1'b1, 16'd200},  {1'b1, 16'd334},
    {1'b1, 16'd469},  {1'b1, 16'd469},  {1'b1, 16'd400},  {1'b0, 16'd300},
    {1'b0, 16'd5000}, {1'b1, 16'd5000}, {1'b1, 16'd4900}, {1'b1, 16'd4800},
    {1'b1, 16'd4700}, {1'b1, 16'd4650}
  };

  logic clk = 1'b0, rst = 1'b1, sample_valid = 1'b0, ref_present = 1'b0;
  logic signed [15:0] phase_err = '0;
  logic [14:0] ctrl_word;
  logic pwm_out, holding, loop_fail;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  longint m_base = 0, m_prev = 0, m_filt = 0, m_acc = 64'd16384 << 12;
  bit m_lock = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  holdover_loop_core dut (
    .clk(clk), .rst(rst), .sample_valid(sample_valid), .phase_err(phase_err),
    .ref_present(ref_present), .ctrl_word(ctrl_word), .pwm_out(pwm_out),
    .holding(holding), .loop_fail(loop_fail)
  );

  function automatic string tag_of(int i);
    case (i)
      0: return "R2";
      3, 4: return "R4";
      5, 9: return "R6";
      7: return "R10";
      8: return "R5";
      default: return "R3";
    endcase
  endfunction

  task automatic chk(string tag, longint act, longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int m_ctrl();
    return int'(m_acc >>> 12);
  endfunction

  function automatic bit m_fail();
    return (m_ctrl() < 1024) || (m_ctrl() > 31743);
  endfunction

  task automatic model(bit r, int ph);
    longint e, d;
    if (!m_lock) begin
      if (r) begin m_base = ph; m_prev = ph; m_filt = 0; m_lock = 1; end
    end else if (!r) begin
      m_lock = 0;
    end else begin
      d = ph - m_prev;
      if (d > 134 || d < -134) m_lock = 0;
      else begin
        e = ph - m_base;
        m_filt = m_filt + (((e <<< 12) - m_filt) >>> 3);
        m_acc  = m_acc + (m_filt >>> 4);
        if (m_acc < 0) m_acc = 0;
        if (m_acc > (64'd1 << 27) - 1) m_acc = (64'd1 << 27) - 1;
        m_prev = ph;
      end
    end
  endtask

  task automatic do_sample(bit r, int ph, string tag);
    @(negedge clk);
    ref_present = r; phase_err = 16'(ph); sample_valid = 1'b1;
    @(negedge clk);
    sample_valid = 1'b0;
    repeat (2) @(negedge clk);
    model(r, ph);
    chk(tag, ctrl_word, m_ctrl());
    chk(tag, holding, !m_lock);
    chk("R8", loop_fail, m_fail());
  endtask

  task automatic pwm_count(string tag, int exp);
    int highs = 0;
    for (int k = 0; k < PERIOD; k++) begin
      @(negedge clk);
      if (pwm_out) highs++;
    end
    chk(tag, highs, exp);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int ph;
    bit seen_fail;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1", ctrl_word, 16384);
    chk("R1", holding, 1);
    chk("R1", loop_fail, 0);
    // R9 first period at mid-scale duty
    pwm_count("R9", 16384);

    // table walk: R2 R3 R4 R5 R6 R10
    for (int i = 0; i < NVEC; i++)
      do_sample(VEC[i][16], int'($signed(VEC[i][15:0])), tag_of(i));

    // R5 reference loss without a sample
    @(negedge clk); ref_present = 1'b0;
    @(negedge clk);
    chk("R5", holding, 1);
    m_lock = 0;
    repeat (3) @(negedge clk);
    chk("R5", ctrl_word, m_ctrl());

    // R9 duty reloads at the boundary to the frozen value
    repeat (PERIOD + 2) @(negedge clk);
    pwm_count("R9", m_ctrl());

    // R7/R8 drive low: restart at a high base, ramp down
    do_sample(1'b1, 30000, "R6");
    ph = 30000; seen_fail = 0;
    for (int k = 0; k < 120; k++) begin
      ph -= 130;
      do_sample(1'b1, ph, "R7");
      if (loop_fail && !seen_fail) begin
        seen_fail = 1;
        chk("R8", (ctrl_word < 1024), 1);
      end
    end
    chk("R7", ctrl_word, 0);
    chk("R8", loop_fail, 1);

    // R4 jump opens, then R6 restart at a low base, ramp up
    do_sample(1'b1, -30000, "R4");
    chk("R4", holding, 1);
    do_sample(1'b1, -30000, "R6");
    ph = -30000;
    for (int k = 0; k < 140; k++) begin
      ph += 130;
      do_sample(1'b1, ph, "R7");
    end
    chk("R7", ctrl_word, 32767);
    chk("R8", loop_fail, 1);

    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule